// File: doc/BRIEF.md
# Multiplexed Clock Display Serial Frame Driver

This block refreshes a four-digit, seven-segment time display through an external serial shift register that has only a data line and a clock line. Every time a 1 kHz tick arrives, the driver moves the scan to the next digit. It then shifts out one 12-bit frame for that digit. The frame holds an active-low digit-select field, an active-low decimal point and seven active-low segment bits.

The external register has no separate latch strobe. It copies its shift stage to its outputs only when the data line is high at the falling clock edge of the last bit. For every earlier bit the driver pulls data low while the clock is still high. For the last bit it raises data during the clock-high phase.

The driver takes the hour (0 to 23), the minute (0 to 59) and the millisecond count within the current second. All three are captured when a frame starts. An hour tens digit of zero is blanked. The dot on the hour-units digit blinks: it is on for the first half of each second.

Top module: `disp_frame_driver`

## Requirements
- R1: Each accepted tick sends one frame for the current scan position and then advances the position by one, wrapping from 3 to 0. Position 0 is hour tens, 1 is hour units, 2 is minute tens and 3 is minute units.
- R2: A frame is 12 bits, sent first to last as 4 select bits, 1 dot bit and 7 segment bits. Every bit is active low. The select field holds a single 0 at the active position, first-sent bit first: position 0 gives 0111, 1 gives 1011, 2 gives 1101 and 3 gives 1110.
- R3: For bits 1 to 11 the data line is low at the falling clock edge, so the register never latches before the frame is complete.
- R4: The data bit is set up before the clock rises and is held across the rise. On the 12th bit the data line is high at the falling clock edge. For a 0 bit it is raised during the clock-high phase.
- R5: Segment fields, first-sent bit first: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000011, 7=1111000, 8=0000000, 9=0011000, blank=1111111.
- R6: When the hour is below 10, the hour-tens digit is sent as blank.
- R7: The dot bit is 0 (lit) only on the hour-units digit, and only while the millisecond count is below 500. In every other case it is 1.
- R8: Each clock phase lasts HALF_CYCLES system clocks, so the clock is high for 2*HALF_CYCLES system clocks per bit. The latching fall happens 47*HALF_CYCLES cycles after the tick is sampled, and the lines return low at 48*HALF_CYCLES.
- R9: Hour, minute and millisecond count are captured on the cycle the tick is accepted. Later changes do not affect the frame in flight.
- R10: A tick that arrives while a frame is being sent is ignored. It does not advance the scan and does not start an extra frame.
- R11: After reset both serial lines are low, they stay low while no frame is being sent, and the first frame is for position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle refresh pulse at 1 kHz |
| hour | input | 5 | Hour of day, 0 to 23 |
| minute | input | 6 | Minute, 0 to 59 |
| ms_count | input | 10 | Millisecond within the second, 0 to 999 |
| ser_data | output | 1 | Serial data line to the shift register |
| ser_clk | output | 1 | Serial clock line to the shift register |

## Verification
The bench decodes the two lines the way the external register would: it shifts on each rising clock edge and latches only on a high-data fall after exactly twelve bits. A design that let data stay high through an earlier fall would therefore latch a partial frame, and the bench flags it at that fall. The sweep covers every hour, every minute and the dot threshold at 499 and 500. This catches a wrong segment code, a zero hour-tens digit that is not blanked, a dot that is off by one or sits on the wrong digit, and a scan that is rotated. Inputs are changed mid-frame and extra ticks are injected mid-frame. A driver that re-reads its inputs during the frame, or that restarts or skips a digit on a busy tick, produces a mismatched frame or an extra latch.

// File: rtl/disp_frame_pkg.sv
package disp_frame_pkg;

  localparam int SEL_W   = 4;
  localparam int DOT_W   = 1;
  localparam int SEG_W   = 7;
  localparam int FRAME_W = SEL_W + DOT_W + SEG_W;
  localparam int DIGITS  = SEL_W;

  localparam logic [3:0] BLANK_CODE = 4'hF;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_RISE  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_FALL  = 2'd3
  } phase_e;

  // Active-low segments, index 6 (g) is sent first, index 0 (a) last.
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [3:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000011;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0011000;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction

  function automatic logic [3:0] tens_digit(input logic [6:0] v);
    logic [3:0] t;
    t = 4'd0;
    for (int i = 1; i < 10; i++) begin
      if (v >= 7'(10 * i)) t = 4'(i);
    end
    return t;
  endfunction

  function automatic logic [3:0] unit_digit(input logic [6:0] v);
    logic [6:0] r;
    r = v - 7'(10 * int'(tens_digit(v)));
    return r[3:0];
  endfunction

endpackage

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int COUNT = 4,
  localparam int W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] idx
);

  logic [W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance) begin
      if (idx_q == W'(COUNT - 1)) idx_q <= '0;
      else                        idx_q <= idx_q + W'(1);
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/disp_frame_build.sv
module disp_frame_build
  import disp_frame_pkg::*;
#(
  parameter int HOUR_W    = 5,
  parameter int MIN_W     = 6,
  parameter int MS_W      = 10,
  parameter int DOT_LIMIT = 500,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [HOUR_W-1:0]  hour,
  input  logic [MIN_W-1:0]   minute,
  input  logic [MS_W-1:0]    ms_count,
  output logic [FRAME_W-1:0] frame
);

  logic [6:0]       hour_ext;
  logic [6:0]       min_ext;
  logic [SEL_W-1:0] sel_n;
  logic             dot_n;
  logic [3:0]       code;
  logic [3:0]       hour_tens;

  assign hour_ext  = 7'(hour);
  assign min_ext   = 7'(minute);
  assign hour_tens = tens_digit(hour_ext);

  // One select bit per position, first-sent bit belongs to position 0.
  for (genvar k = 0; k < SEL_W; k++) begin : g_sel
    assign sel_n[SEL_W-1-k] = (idx != IDX_W'(k));
  end

  always_comb begin
    case (idx)
      IDX_W'(0): code = (hour_tens == 4'd0) ? BLANK_CODE : hour_tens;
      IDX_W'(1): code = unit_digit(hour_ext);
      IDX_W'(2): code = tens_digit(min_ext);
      default:   code = unit_digit(min_ext);
    endcase
  end

  assign dot_n = !((idx == IDX_W'(1)) && (ms_count < MS_W'(DOT_LIMIT)));
  assign frame = {sel_n, dot_n, seg_pattern(code)};

endmodule

// File: rtl/disp_bit_seq.sv
module disp_bit_seq
  import disp_frame_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int HALF_CYCLES = 2,
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1,
  localparam int BIT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] frame_in,
  output logic             busy,
  output logic             last_bit,
  output logic             ser_data,
  output logic             ser_clk
);

  logic             busy_q, busy_n;
  logic [WIDTH-1:0] sh_q, sh_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  phase_e           ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             data_q, data_n;
  logic             clk_q, clk_n;
  logic             last_q, last_n;

  assign last_q = (bit_q == BIT_W'(WIDTH - 1));
  assign last_n = (bit_n == BIT_W'(WIDTH - 1));

  always_comb begin
    busy_n = busy_q;
    sh_n   = sh_q;
    bit_n  = bit_q;
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      sh_n   = frame_in;
      bit_n  = '0;
      ph_n   = PH_SETUP;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(HALF_CYCLES - 1)) begin
        cnt_n = '0;
        case (ph_q)
          PH_SETUP: ph_n = PH_RISE;
          PH_RISE:  ph_n = PH_HOLD;
          PH_HOLD:  ph_n = PH_FALL;
          default: begin
            ph_n = PH_SETUP;
            if (last_q) begin
              busy_n = 1'b0;
            end else begin
              bit_n = bit_q + BIT_W'(1);
              sh_n  = {sh_q[WIDTH-2:0], 1'b0};
            end
          end
        endcase
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  // Line levels derived from the next state, so outputs leave a flop.
  always_comb begin
    clk_n  = busy_n && (ph_n == PH_RISE || ph_n == PH_HOLD);
    if (!busy_n)
      data_n = 1'b0;
    else if (ph_n == PH_SETUP || ph_n == PH_RISE)
      data_n = sh_n[WIDTH-1];
    else
      data_n = last_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      ph_q   <= PH_SETUP;
      cnt_q  <= '0;
      data_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      data_q <= data_n;
      clk_q  <= clk_n;
    end
  end

  assign busy     = busy_q;
  assign last_bit = last_q;
  assign ser_data = data_q;
  assign ser_clk  = clk_q;

endmodule

// File: rtl/disp_frame_driver.sv
module disp_frame_driver
  import disp_frame_pkg::*;
#(
  parameter int HOUR_W      = 5,
  parameter int MIN_W       = 6,
  parameter int MS_W        = 10,
  parameter int DOT_LIMIT   = 500,
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [HOUR_W-1:0] hour,
  input  logic [MIN_W-1:0]  minute,
  input  logic [MS_W-1:0]   ms_count,
  output logic              ser_data,
  output logic              ser_clk
);

  localparam int IDX_W = $clog2(DIGITS);

  logic               seq_busy;
  logic               seq_last;
  logic               tick_ok;
  logic [IDX_W-1:0]   scan_idx;
  logic [FRAME_W-1:0] frame_w;

  assign tick_ok = tick && !seq_busy;

  disp_scan #(
    .COUNT(DIGITS)
  ) u_scan (
    .clk     (clk),
    .rst     (rst),
    .advance (tick_ok),
    .idx     (scan_idx)
  );

  disp_frame_build #(
    .HOUR_W    (HOUR_W),
    .MIN_W     (MIN_W),
    .MS_W      (MS_W),
    .DOT_LIMIT (DOT_LIMIT),
    .IDX_W     (IDX_W)
  ) u_build (
    .idx      (scan_idx),
    .hour     (hour),
    .minute   (minute),
    .ms_count (ms_count),
    .frame    (frame_w)
  );

  disp_bit_seq #(
    .WIDTH       (FRAME_W),
    .HALF_CYCLES (HALF_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (tick_ok),
    .frame_in (frame_w),
    .busy     (seq_busy),
    .last_bit (seq_last),
    .ser_data (ser_data),
    .ser_clk  (ser_clk)
  );

endmodule

// File: rtl/disp_frame_driver_chk.sv
module disp_frame_driver_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             busy,
  input logic             last_bit,
  input logic [IDX_W-1:0] scan,
  input logic             ser_data,
  input logic             ser_clk
);

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy) |=> (scan == $past(scan) + IDX_W'(1))); // R1

  AST_FALL_LATCH_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> (ser_data == last_bit)); // R3

  AST_DATA_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data)); // R4

  AST_CLK_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |=> ser_clk); // R8

  AST_BUSY_TICK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (tick && busy) |=> $stable(scan)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_data)); // R11

endmodule

bind disp_frame_driver disp_frame_driver_chk #(
  .IDX_W (IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .busy     (seq_busy),
  .last_bit (seq_last),
  .scan     (scan_idx),
  .ser_data (ser_data),
  .ser_clk  (ser_clk)
);

// File: tb/disp_frame_driver_tb.sv
module disp_frame_driver_tb;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [4:0] hour = '0;
  logic [5:0] minute = '0;
  logic [9:0] ms_count = '0;
  logic       ser_data;
  logic       ser_clk;

  int checks = 0;
  int fails  = 0;
  int latch_cnt = 0;
  logic [11:0] latched = '0;
  int exp_digit = 0;

  always #2.5 clk = ~clk;

  disp_frame_driver #(.HALF_CYCLES(HALF)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .hour(hour), .minute(minute),
    .ms_count(ms_count), .ser_data(ser_data), .ser_clk(ser_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] seg_of(input int v);
    case (v)
      0: return 7'b1000000;  1: return 7'b1111001;
      2: return 7'b0100100;  3: return 7'b0110000;
      4: return 7'b0011001;  5: return 7'b0010010;
      6: return 7'b0000011;  7: return 7'b1111000;
      8: return 7'b0000000;  9: return 7'b0011000;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic logic [11:0] exp_frame(input int d, input int h, input int m, input int ms);
    logic [3:0] sel;
    logic       dot;
    int         v;
    sel = 4'b1111 & ~(4'b1000 >> d);
    dot = (d == 1 && ms < 500) ? 1'b0 : 1'b1;
    case (d)
      0: v = (h / 10 == 0) ? 15 : h / 10;
      1: v = h % 10;
      2: v = m / 10;
      default: v = m % 10;
    endcase
    return {sel, dot, seg_of(v)};
  endfunction

  // Receiver model: shift on rise, latch on high-data fall after 12 bits.
  logic [11:0] rx_sh = '0;
  int rx_bits = 0;
  int hi_len = 0;
  logic prev_clk = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      rx_bits = 0; hi_len = 0; prev_clk = 1'b0;
    end else begin
      if (ser_clk && !prev_clk) begin
        rx_sh = {rx_sh[10:0], ser_data};
        rx_bits++;
        hi_len = 1;
      end else if (ser_clk) begin
        hi_len++;
      end
      if (!ser_clk && prev_clk) begin
        chk(hi_len == 2 * HALF, "R8 clock high width", hi_len, 2 * HALF);
        if (rx_bits < 12)
          chk(!ser_data, "R3 data low at early fall", ser_data, 0);
        else
          chk(ser_data, "R4 data high at last fall", ser_data, 1);
        if (ser_data && rx_bits == 12) begin
          latched = rx_sh;
          latch_cnt++;
        end
        if (ser_data || rx_bits >= 12) rx_bits = 0;
      end
      prev_clk = ser_clk;
    end
  end

  task automatic run_frame(input int h, input int m, input int ms,
                           input bit change_mid, input bit extra_tick);
    int n;
    int lc0;
    logic [11:0] exp;
    string tag;
    exp = exp_frame(exp_digit, h, m, ms);
    hour = 5'(h); minute = 6'(m); ms_count = 10'(ms);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    n = 0; lc0 = latch_cnt;
    while (latch_cnt == lc0 && n < 1000) begin
      @(negedge clk); n++;
      if (n == 5 && change_mid) begin
        hour = 5'((h + 7) % 24); minute = 6'((m + 31) % 60); ms_count = 10'((ms + 500) % 1000);
      end
      if (n == 10 && extra_tick) tick = 1'b1;
      if (n == 11) tick = 1'b0;
    end
    chk(n == 47 * HALF, "R8 latch timing", n, 47 * HALF);
    if (exp_digit == 0 && h < 10) tag = "R6 blank hour tens";
    else if (exp_digit == 1) tag = "R7 dot blink";
    else tag = "R5 segments";
    if (change_mid) tag = {tag, " R9 sampled inputs"};
    chk(latched == exp, {tag, " R1 R2 frame"}, latched, exp);
    repeat (HALF + 2) @(negedge clk);
    chk(!ser_clk && !ser_data, "R11 idle lines", {ser_clk, ser_data}, 0);
    if (extra_tick)
      chk(latch_cnt == lc0 + 1, "R10 busy tick ignored", latch_cnt - lc0, 1);
    exp_digit = (exp_digit + 1) % 4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ser_clk && !ser_data, "R11 reset lines", {ser_clk, ser_data}, 0);
    // First frame after reset must be position 0.
    for (int h = 0; h < 24; h++) begin
      for (int k = 0; k < 4; k++) begin
        int ms;
        case (h % 4)
          0: ms = 0;
          1: ms = 499;
          2: ms = 500;
          default: ms = 999;
        endcase
        run_frame(h, (h * 7 + k * 11) % 60, ms, (h % 3 == 0), (h % 5 == 0 && k == 2));
      end
    end
    for (int m = 0; m < 60; m++) begin
      for (int k = 0; k < 4; k++) begin
        run_frame((m * 5) % 24, m, (m * 17 + k * 250) % 1000, (m % 4 == 1), (m % 7 == 3));
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule